// File: doc/BRIEF.md
# Three-Wire Serial Memory Slave

This block acts as the memory device on a three-wire serial bus. A master drives chip select, a serial clock and a serial data input. The block returns read data on one serial output, with a separate output enable that stands in for high impedance. The bus pins are asynchronous to the block. A faster system clock synchronizes them, and every action happens on a detected rising edge of the serial clock.

Each transaction begins with a start bit. An opcode and an address follow, most significant bit first. A read returns one dummy zero and then streams words for as long as the master keeps clocking, stepping the address and wrapping at the top. A write stores one word, but only while an internal write-enable flag is set. That flag is cleared by reset and is controlled by two extended commands. The storage is a 4096-bit register array. A static parameter selects 16-bit words (256 locations, 8 address bits) or 8-bit words (512 locations, 9 address bits).

Top module: `mw_mem_slave`

## Requirements
- R1: After reset, and for every bit of a command up to the last address bit, `mw_do_oe` is 0. It goes to 1 only once the final address bit of a READ has been clocked in.
- R2: A command is a start bit 1, then a 2-bit opcode (10 READ, 01 WRITE, 00 extended), then the address MSB first. On the last address bit of a READ, DO presents a single 0. Each later serial clock rising edge presents the next data bit, MSB first. DO does not change between rising edges.
- R3: With chip select held and the clock running, the word at the next address follows right after the last bit of the previous word, with no gap bit.
- R4: Streaming past the last location continues at address 0.
- R5: After reset the write-enable flag is clear. A WRITE (opcode 01, address, then one data word MSB first) then leaves memory unchanged.
- R6: The extended command whose top two address bits are 11 sets the flag. A following WRITE then stores its word at the addressed location.
- R7: The extended command whose top two address bits are 00 clears the flag, and later WRITEs are ignored again.
- R8: READ returns stored contents whether the flag is set or clear.
- R9: Dropping chip select at any point ends the command. DO returns to disabled, and the next command is decoded from its start bit. A WRITE cut off before its last data bit stores nothing.
- R10: While chip select is high and no command is active, 0 bits on the data input are ignored until the first 1 arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mw_cs | input | 1 | Chip select, active high |
| mw_sk | input | 1 | Serial clock from the master |
| mw_di | input | 1 | Serial data from the master |
| mw_do | output | 1 | Serial read data, 0 while disabled |
| mw_do_oe | output | 1 | Output enable for the data line; 0 means high impedance |

## Verification
A corrupted decoder state shows up at the ports within one serial clock. The output enable either rises during a write or extended command, or fails to rise after a read address. A stale or corrupted write-enable flag only becomes visible on a later read-back of the addressed word, so every write is followed by a read. An address counter fault appears at the first word boundary of a streamed read. For that reason, reads span two words and include the wrap from the top location to location 0.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_READ,
        ST_WDATA,
        ST_HOLD
    } mw_state_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;
    localparam logic [1:0] OPC_EXT   = 2'b00;

    localparam logic [1:0] EXT_ENABLE  = 2'b11;
    localparam logic [1:0] EXT_DISABLE = 2'b00;

endpackage

// File: rtl/mw_pin_sync.sv
module mw_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_o,
    output logic di_o,
    output logic sk_rise_o
);

    logic [2:0] stg_q [STAGES];
    logic       sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
            sk_prev_q <= 1'b0;
        end else begin
            stg_q[0] <= {cs_i, sk_i, di_i};
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
            sk_prev_q <= stg_q[STAGES-1][1];
        end
    end

    assign cs_o      = stg_q[STAGES-1][2];
    assign di_o      = stg_q[STAGES-1][0];
    assign sk_rise_o = stg_q[STAGES-1][1] & ~sk_prev_q;

endmodule

// File: rtl/mw_word_store.sv
module mw_word_store #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 256,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o
);

    logic [WORD_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we_i) begin
            mem_q[waddr_i] <= wdata_i;
        end
    end

    assign rdata_o = mem_q[raddr_i];

endmodule

// File: rtl/mw_cmd_ctrl.sv
module mw_cmd_ctrl
    import mw_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 8,
    localparam int MAX_W = (WORD_W > ADDR_W) ? WORD_W : ADDR_W,
    localparam int CNT_W = $clog2(MAX_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_i,
    input  logic              di_i,
    input  logic              sk_rise_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [WORD_W-1:0] rd_data_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [WORD_W-1:0] wdata_o,
    output logic              do_o,
    output logic              oe_o,
    output logic              wen_o,
    output logic              in_read_o
);

    typedef struct packed {
        mw_state_e         state;
        logic [1:0]        opc;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] sh;
        logic              wen;
        logic              oe;
        logic              dout;
    } ctrl_t;

    ctrl_t q, d;

    logic [ADDR_W-1:0] addr_shift;
    logic              addr_last;
    logic              word_last;

    assign addr_shift = {q.addr[ADDR_W-2:0], di_i};
    assign addr_last  = (q.cnt == CNT_W'(ADDR_W - 1));
    assign word_last  = (q.cnt == CNT_W'(WORD_W - 1));

    // read address: captured address at the end of a READ header,
    // the following location at a word boundary, otherwise the current one
    always_comb begin
        rd_addr_o = q.addr;
        if (sk_rise_i && cs_i) begin
            if (q.state == ST_ADDR && addr_last && q.opc == OPC_READ)
                rd_addr_o = addr_shift;
            else if (q.state == ST_READ && word_last)
                rd_addr_o = ADDR_W'(q.addr + 1'b1);
        end
    end

    always_comb begin
        d       = q;
        we_o    = 1'b0;
        waddr_o = q.addr;
        wdata_o = {q.sh[WORD_W-2:0], di_i};

        if (!cs_i) begin
            d.state = ST_IDLE;
            d.oe    = 1'b0;
            d.dout  = 1'b0;
            d.cnt   = '0;
        end else if (sk_rise_i) begin
            unique case (q.state)
                ST_IDLE: begin
                    if (di_i) begin
                        d.state = ST_OPC;
                        d.cnt   = '0;
                    end
                end
                ST_OPC: begin
                    d.opc = {q.opc[0], di_i};
                    if (q.cnt == CNT_W'(1)) begin
                        d.state = ST_ADDR;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_shift;
                    if (addr_last) begin
                        d.cnt = '0;
                        unique case (q.opc)
                            OPC_READ: begin
                                d.state = ST_READ;
                                d.oe    = 1'b1;
                                d.dout  = 1'b0;
                                d.sh    = rd_data_i;
                            end
                            OPC_WRITE: begin
                                d.state = ST_WDATA;
                            end
                            OPC_EXT: begin
                                if (addr_shift[ADDR_W-1 -: 2] == EXT_ENABLE)
                                    d.wen = 1'b1;
                                else if (addr_shift[ADDR_W-1 -: 2] == EXT_DISABLE)
                                    d.wen = 1'b0;
                                d.state = ST_HOLD;
                            end
                            default: d.state = ST_HOLD;
                        endcase
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_READ: begin
                    d.dout = q.sh[WORD_W-1];
                    if (word_last) begin
                        d.cnt  = '0;
                        d.addr = ADDR_W'(q.addr + 1'b1);
                        d.sh   = rd_data_i;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                        d.sh  = {q.sh[WORD_W-2:0], 1'b0};
                    end
                end
                ST_WDATA: begin
                    d.sh = {q.sh[WORD_W-2:0], di_i};
                    if (word_last) begin
                        we_o    = q.wen;
                        d.state = ST_HOLD;
                        d.cnt   = '0;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
                ST_HOLD: ;
                default: d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.state <= ST_IDLE;
            q.opc   <= '0;
            q.addr  <= '0;
            q.cnt   <= '0;
            q.sh    <= '0;
            q.wen   <= 1'b0;
            q.oe    <= 1'b0;
            q.dout  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign do_o      = q.dout & q.oe;
    assign oe_o      = q.oe;
    assign wen_o     = q.wen;
    assign in_read_o = (q.state == ST_READ);

endmodule

// File: rtl/mw_mem_slave.sv
module mw_mem_slave #(
    parameter int ORG_WIDE  = 1,
    parameter int MEM_BITS  = 4096,
    parameter int SYNC_STGS = 2,
    localparam int WORD_W = (ORG_WIDE != 0) ? 16 : 8,
    localparam int DEPTH  = MEM_BITS / WORD_W,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mw_cs,
    input  logic mw_sk,
    input  logic mw_di,
    output logic mw_do,
    output logic mw_do_oe
);

    logic              cs_s;
    logic              di_s;
    logic              sk_rise;
    logic [ADDR_W-1:0] rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    logic              wen;
    logic              in_read;

    mw_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (mw_cs),
        .sk_i      (mw_sk),
        .di_i      (mw_di),
        .cs_o      (cs_s),
        .di_o      (di_s),
        .sk_rise_o (sk_rise)
    );

    mw_cmd_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_s),
        .di_i      (di_s),
        .sk_rise_i (sk_rise),
        .rd_addr_o (rd_addr),
        .rd_data_i (rd_data),
        .we_o      (mem_we),
        .waddr_o   (mem_waddr),
        .wdata_o   (mem_wdata),
        .do_o      (mw_do),
        .oe_o      (mw_do_oe),
        .wen_o     (wen),
        .in_read_o (in_read)
    );

    mw_word_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

endmodule

// File: rtl/mw_mem_slave_chk.sv
module mw_mem_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic sk_rise,
    input logic in_read,
    input logic mem_we,
    input logic wen,
    input logic mw_do,
    input logic mw_do_oe
);

    AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mw_do_oe |-> in_read);                                      // R1

    AST_FIRST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mw_do_oe) |-> !mw_do);                                // R2

    AST_DO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && !sk_rise) |=> $stable(mw_do));                     // R2

    AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> wen);                                            // R5

    AST_CS_DROP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !mw_do_oe);                                       // R9

endmodule

bind mw_mem_slave mw_mem_slave_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (cs_s),
    .sk_rise  (sk_rise),
    .in_read  (in_read),
    .mem_we   (mem_we),
    .wen      (wen),
    .mw_do    (mw_do),
    .mw_do_oe (mw_do_oe)
);

// File: tb/mw_mem_slave_bench.sv
module mw_mem_slave_bench;

    localparam int W  = 16;
    localparam int AW = 8;
    localparam int DP = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, oe;

    int n_chk = 0;
    int n_fail = 0;
    logic done = 1'b0;

    logic [W-1:0] model [DP];
    logic wen_model = 1'b0;

    always #2 clk = ~clk;

    mw_mem_slave u_mw_mem_slave (
        .clk(clk), .rst_n(rst_n), .mw_cs(cs), .mw_sk(sk), .mw_di(di),
        .mw_do(dout), .mw_do_oe(oe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sk_bit(input logic b, output logic o_do, output logic o_oe);
        @(negedge clk) di = b;
        repeat (3) @(negedge clk);
        sk = 1'b1;
        repeat (6) @(negedge clk);
        o_do = dout;
        o_oe = oe;
        sk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic begin_cmd(input int lead0, input logic [1:0] op, input logic [AW-1:0] a,
                             output logic early_oe, output logic last_oe, output logic last_do);
        logic o, e;
        early_oe = 1'b0;
        @(negedge clk) cs = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 0; i < lead0; i++) begin sk_bit(1'b0, o, e); early_oe |= e; end
        sk_bit(1'b1, o, e); early_oe |= e;
        for (int i = 1; i >= 0; i--) begin sk_bit(op[i], o, e); early_oe |= e; end
        for (int i = AW-1; i >= 0; i--) begin
            sk_bit(a[i], o, e);
            if (i != 0) early_oe |= e;
        end
        last_oe = e;
        last_do = o;
    endtask

    task automatic end_cmd();
        @(negedge clk) cs = 1'b0;
        sk = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] v, input string tag);
        logic eo, lo, ld, o, e;
        begin_cmd(0, 2'b01, a, eo, lo, ld);
        for (int i = W-1; i >= 0; i--) begin
            sk_bit(v[i], o, e);
            eo |= e;
        end
        check({tag, " oe stays low in write"}, {31'd0, eo}, 32'd0);
        end_cmd();
        if (wen_model) model[a] = v;
    endtask

    task automatic do_ext(input logic [1:0] top, input string tag);
        logic eo, lo, ld;
        begin_cmd(0, 2'b00, {top, 6'b101010}, eo, lo, ld);
        check({tag, " oe low in extended"}, {31'd0, eo | lo}, 32'd0);
        end_cmd();
        if (top == 2'b11) wen_model = 1'b1;
        else if (top == 2'b00) wen_model = 1'b0;
    endtask

    task automatic read_seq(input int lead0, input logic [AW-1:0] a, input int nw, input string tag);
        logic eo, lo, ld, o, e;
        logic [W-1:0] got;
        begin_cmd(lead0, 2'b10, a, eo, lo, ld);
        check({tag, " R1 oe low before last address bit"}, {31'd0, eo}, 32'd0);
        check({tag, " R2 dummy zero with oe"}, {30'd0, lo, ld}, 32'd2);
        for (int w = 0; w < nw; w++) begin
            got = '0;
            for (int i = W-1; i >= 0; i--) begin
                sk_bit(1'b0, o, e);
                got[i] = o;
            end
            check($sformatf("%s R3 word %0d at addr %0d", tag, w, (a + w) % DP),
                  {16'd0, got}, {16'd0, model[(a + w) % DP]});
        end
        end_cmd();
        check({tag, " R9 oe off after cs low"}, {31'd0, oe}, 32'd0);
    endtask

    task automatic t_reset();
        check("R1 oe low after reset", {31'd0, oe}, 32'd0);
        check("R1 do low after reset", {31'd0, dout}, 32'd0);
    endtask

    task automatic t_write_locked();
        do_write(8'd5, 16'hA5A5, "R5 locked write");
        read_seq(0, 8'd5, 1, "R5 R8 read after locked write");
    endtask

    task automatic t_enable_and_stream();
        do_ext(2'b11, "R6 enable");
        do_write(8'd5, 16'h1234, "R6 w5");
        do_write(8'd6, 16'hBEEF, "R6 w6");
        do_write(8'd255, 16'hC3C3, "R6 w255");
        do_write(8'd0, 16'h0F0F, "R6 w0");
        read_seq(0, 8'd5, 2, "R6 R3 stream 5..6");
    endtask

    task automatic t_wrap();
        read_seq(0, 8'd255, 2, "R4 wrap");
    endtask

    task automatic t_abort();
        logic eo, lo, ld, o, e;
        begin_cmd(0, 2'b01, 8'd7, eo, lo, ld);
        for (int i = 0; i < 8; i++) sk_bit(1'b1, o, e);
        end_cmd();
        read_seq(0, 8'd7, 1, "R9 cut write");
        begin_cmd(0, 2'b10, 8'd5, eo, lo, ld);
        for (int i = 0; i < 4; i++) sk_bit(1'b0, o, e);
        check("R9 oe high mid read", {31'd0, e}, 32'd1);
        end_cmd();
        check("R9 oe low after abort", {31'd0, oe}, 32'd0);
        read_seq(0, 8'd5, 1, "R9 restart read");
    endtask

    task automatic t_disable();
        do_ext(2'b00, "R7 disable");
        do_write(8'd5, 16'hFFFF, "R7 write after disable");
        read_seq(0, 8'd5, 1, "R7 R8 read with flag clear");
    endtask

    task automatic t_lead_zeros();
        read_seq(3, 8'd6, 1, "R10 leading zeros");
    endtask

    initial begin
        for (int i = 0; i < DP; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_locked();
        t_enable_and_stream();
        t_wrap();
        t_abort();
        t_disable();
        t_lead_zeros();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule